// File: doc/BRIEF.md
# Masked Address Breakpoint Comparator

This block watches every bus cycle on a monitored bus and requests a break interrupt when the cycle's address equals a programmed 32-bit break address. Every address bit can be excluded from the comparison on its own, so a single breakpoint can cover an aligned region, a stride of addresses or a whole window. A two-bit cycle selector limits the breakpoint to cycles started by the CPU, to cycles started by the DMA-style transfer controller, or to both. It can also switch the breakpoint off entirely.

Software programs the block through a word-addressed 16-bit register port. The port gives access to the break address and the mask, each split into a high half and a low half, and to a condition register that carries the selector. A qualifying cycle produces a one-clock request one clock after the cycle is seen on the bus.

Top module: `brk_addr_watch`

## Requirements
- R1: After reset, every register reads 0 and no bus cycle produces a break request.
- R2: Register word addresses are 0 for break address bits 31..16, 1 for break address bits 15..0, 2 for mask bits 31..16, 3 for mask bits 15..0, and 4 for the condition register. Each of these reads back the last value written to it. Addresses 5 to 7 read 0, and a write to them changes no register.
- R3: In the condition register, bits 15..8 always read 0 and cannot be set by a write. Bits 5..0 are stored and read back, but they have no effect on matching.
- R4: A mask bit of 1 removes that address bit from the comparison, so a bus address that differs from the break address only in masked bits still breaks.
- R5: A mask bit of 0 keeps that address bit in the comparison, so any difference in an unmasked bit prevents a break.
- R6: Condition bits 7..6 = 00 blocks all break requests, for both master types.
- R7: Condition bits 7..6 = 01 allows breaks only on CPU cycles (busIsDma = 0).
- R8: Condition bits 7..6 = 10 allows breaks only on transfer-controller cycles (busIsDma = 1).
- R9: Condition bits 7..6 = 11 allows breaks on cycles from either master.
- R10: A cycle with busValid low never produces a break request.
- R11: brkReq goes high in the clock after a qualifying cycle. It stays high for that one clock only, unless the next cycle also qualifies.
- R12: Mask bits 31..16 come from the high mask register and bits 15..0 from the low one, each acting only on its own address half.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rstN | input | 1 | Active-low synchronous reset |
| regAddr | input | 3 | Register word address |
| regWrEn | input | 1 | Register write strobe |
| regWrData | input | 16 | Register write data |
| regRdData | output | 16 | Register read data for regAddr |
| busValid | input | 1 | A bus cycle is present this clock |
| busAddr | input | 32 | Address of the bus cycle |
| busIsDma | input | 1 | 1 = transfer-controller cycle, 0 = CPU cycle |
| brkReq | output | 1 | Break interrupt request pulse |

## Verification
The hardest cases to reach are the ones where the comparison result and the master gate disagree. One is a bus address that differs from the break address only in masked bits, in either half. Another is an exact match whose master type the selector has turned off. The bench sets up a mask over a few low bits and a separate mask over the top byte. It then places addresses just inside and just outside those masks. After that it runs all four selector codes against both master types, using an exact address match, so that only the gate decides the result.

// File: rtl/brkw_pkg.sv
package brkw_pkg;
  localparam int ADDR_W = 32;
  localparam int HALF_W = 16;
  localparam int REG_AW = 3;

  typedef enum logic [REG_AW-1:0] {
    REG_ADDR_HI = 3'd0,
    REG_ADDR_LO = 3'd1,
    REG_MASK_HI = 3'd2,
    REG_MASK_LO = 3'd3,
    REG_COND    = 3'd4
  } regSel_e;

  // configuration strobes handed from control to datapath
  typedef struct packed {
    logic [ADDR_W-1:0] brkAddr;
    logic [ADDR_W-1:0] brkMask;
    logic              cpuEn;
    logic              dmaEn;
  } brkCfg_t;
endpackage

// File: rtl/brkw_regs.sv
module brkw_regs
  import brkw_pkg::*;
#(
  parameter int DW     = HALF_W,
  parameter int AW     = REG_AW,
  parameter int SEL_LO = 6,
  parameter int COND_W = 8
) (
  input  logic          clk,
  input  logic          rstN,
  input  logic [AW-1:0] regAddr,
  input  logic          regWrEn,
  input  logic [DW-1:0] regWrData,
  output logic [DW-1:0] regRdData,
  output brkCfg_t       cfg
);
  localparam int NHALF = 2;

  logic [DW-1:0]     addrHalf [NHALF];
  logic [DW-1:0]     maskHalf [NHALF];
  logic [COND_W-1:0] condReg;

  // half 1 = high word (even address), half 0 = low word (odd address)
  for (genvar h = 0; h < NHALF; h++) begin : g_half
    localparam logic [AW-1:0] A_SEL = (h == 1) ? REG_ADDR_HI : REG_ADDR_LO;
    localparam logic [AW-1:0] M_SEL = (h == 1) ? REG_MASK_HI : REG_MASK_LO;
    always_ff @(posedge clk) begin
      if (!rstN) begin
        addrHalf[h] <= '0;
        maskHalf[h] <= '0;
      end else if (regWrEn) begin
        if (regAddr == A_SEL) addrHalf[h] <= regWrData;
        if (regAddr == M_SEL) maskHalf[h] <= regWrData;
      end
    end
  end

  always_ff @(posedge clk) begin
    if (!rstN)                              condReg <= '0;
    else if (regWrEn && regAddr == REG_COND) condReg <= regWrData[COND_W-1:0];
  end

  always_comb begin
    regRdData = '0;
    case (regAddr)
      REG_ADDR_HI: regRdData = addrHalf[1];
      REG_ADDR_LO: regRdData = addrHalf[0];
      REG_MASK_HI: regRdData = maskHalf[1];
      REG_MASK_LO: regRdData = maskHalf[0];
      REG_COND:    regRdData = {{(DW-COND_W){1'b0}}, condReg};
      default:     regRdData = '0;
    endcase
  end

  always_comb begin
    cfg.brkAddr = {addrHalf[1], addrHalf[0]};
    cfg.brkMask = {maskHalf[1], maskHalf[0]};
    cfg.cpuEn   = condReg[SEL_LO];
    cfg.dmaEn   = condReg[SEL_LO+1];
  end

  // R3: upper condition byte never reads as set
  p_rsvd_zero_r3: assert property (@(posedge clk) disable iff (!rstN)
    (regAddr == REG_COND) |-> (regRdData[DW-1:COND_W] == '0));
  // R2: unused word addresses read zero
  p_hole_zero_r2: assert property (@(posedge clk) disable iff (!rstN)
    (regAddr > REG_COND) |-> (regRdData == '0));
  // R2: with no write strobe the configuration holds
  p_cfg_hold_r2: assert property (@(posedge clk) disable iff (!rstN)
    !regWrEn |=> $stable(cfg));
endmodule

// File: rtl/brkw_match.sv
module brkw_match
  import brkw_pkg::*;
#(
  parameter int AW  = ADDR_W,
  parameter int SEG = HALF_W
) (
  input  logic          clk,
  input  logic          rstN,
  input  brkCfg_t       cfg,
  input  logic          busValid,
  input  logic [AW-1:0] busAddr,
  input  logic          busIsDma,
  output logic          brkReq
);
  localparam int NSEG = AW / SEG;

  logic [NSEG-1:0] segHit;
  logic            addrHit;
  logic            masterOk;
  logic            cycleHit;

  // compare each address segment separately, then combine
  for (genvar s = 0; s < NSEG; s++) begin : g_seg
    logic [SEG-1:0] diff;
    assign diff      = (busAddr[s*SEG +: SEG] ^ cfg.brkAddr[s*SEG +: SEG])
                       & ~cfg.brkMask[s*SEG +: SEG];
    assign segHit[s] = (diff == '0);
  end

  assign addrHit  = &segHit;
  assign masterOk = busIsDma ? cfg.dmaEn : cfg.cpuEn;
  assign cycleHit = busValid && addrHit && masterOk;

  always_ff @(posedge clk) begin
    if (!rstN) brkReq <= 1'b0;
    else       brkReq <= cycleHit;
  end

  // R10: a request always follows a valid cycle
  p_need_valid_r10: assert property (@(posedge clk) disable iff (!rstN)
    brkReq |-> $past(busValid));
  // R6: selector code 00 never lets a request through
  p_sel_off_r6: assert property (@(posedge clk) disable iff (!rstN)
    brkReq |-> $past(cfg.cpuEn || cfg.dmaEn));
  // R7 / R8: master type must be enabled in the cycle seen
  p_master_gate_r7: assert property (@(posedge clk) disable iff (!rstN)
    brkReq |-> ($past(busIsDma) ? $past(cfg.dmaEn) : $past(cfg.cpuEn)));
  // R5: no request when an unmasked bit differed
  p_unmasked_eq_r5: assert property (@(posedge clk) disable iff (!rstN)
    brkReq |-> ($past((busAddr ^ cfg.brkAddr) & ~cfg.brkMask) == '0));
  // R11: a request with no valid cycle beforehand drops next clock
  p_pulse_r11: assert property (@(posedge clk) disable iff (!rstN)
    (brkReq && !busValid) |=> !brkReq);
endmodule

// File: rtl/brk_addr_watch.sv
module brk_addr_watch
  import brkw_pkg::*;
(
  input  logic              clk,
  input  logic              rstN,
  input  logic [REG_AW-1:0] regAddr,
  input  logic              regWrEn,
  input  logic [HALF_W-1:0] regWrData,
  output logic [HALF_W-1:0] regRdData,
  input  logic              busValid,
  input  logic [ADDR_W-1:0] busAddr,
  input  logic              busIsDma,
  output logic              brkReq
);
  brkCfg_t cfg;

  brkw_regs #(.DW(HALF_W), .AW(REG_AW)) u_regs (
    .clk(clk), .rstN(rstN), .regAddr(regAddr), .regWrEn(regWrEn),
    .regWrData(regWrData), .regRdData(regRdData), .cfg(cfg)
  );

  brkw_match #(.AW(ADDR_W), .SEG(HALF_W)) u_match (
    .clk(clk), .rstN(rstN), .cfg(cfg), .busValid(busValid),
    .busAddr(busAddr), .busIsDma(busIsDma), .brkReq(brkReq)
  );
endmodule

// File: tb/sim_brk_addr_watch.sv
module sim_brk_addr_watch;
  logic        clk = 1'b0;
  logic        rstN = 1'b0;
  logic [2:0]  regAddr = '0;
  logic        regWrEn = 1'b0;
  logic [15:0] regWrData = '0;
  logic [15:0] regRdData;
  logic        busValid = 1'b0;
  logic [31:0] busAddr = '0;
  logic        busIsDma = 1'b0;
  logic        brkReq;

  int nChk = 0;
  int nBad = 0;

  always #10 clk = ~clk; // 50 MHz

  brk_addr_watch u0 (
    .clk(clk), .rstN(rstN), .regAddr(regAddr), .regWrEn(regWrEn),
    .regWrData(regWrData), .regRdData(regRdData), .busValid(busValid),
    .busAddr(busAddr), .busIsDma(busIsDma), .brkReq(brkReq)
  );

  task automatic chk(input string tag, input logic [31:0] act, input logic [31:0] exp);
    nChk++;
    if (act !== exp) begin
      nBad++;
      $display("FAIL %s: actual %h expected %h", tag, act, exp);
    end
  endtask

  task automatic regWrite(input logic [2:0] a, input logic [15:0] d);
    @(negedge clk);
    regAddr = a; regWrData = d; regWrEn = 1'b1;
    @(negedge clk);
    regWrEn = 1'b0;
  endtask

  task automatic regRead(input logic [2:0] a, output logic [15:0] d);
    @(negedge clk);
    regAddr = a;
    #2 d = regRdData;
  endtask

  task automatic setBrk(input logic [31:0] a, input logic [31:0] m, input logic [15:0] c);
    regWrite(3'd0, a[31:16]); regWrite(3'd1, a[15:0]);
    regWrite(3'd2, m[31:16]); regWrite(3'd3, m[15:0]);
    regWrite(3'd4, c);
  endtask

  // one bus cycle; checks the request clock and the one after it (R11)
  task automatic busCycle(input string tag, input logic [31:0] a, input logic dma,
                          input logic vld, input logic expBrk);
    @(negedge clk);
    busAddr = a; busIsDma = dma; busValid = vld;
    @(negedge clk);
    chk(tag, {31'd0, brkReq}, {31'd0, expBrk});
    busValid = 1'b0;
    @(negedge clk);
    chk("R11 pulse drops", {31'd0, brkReq}, 32'd0);
  endtask

  task automatic t_reset();
    logic [15:0] d;
    for (int a = 0; a < 5; a++) begin
      regRead(a[2:0], d);
      chk("R1 reset value", {16'd0, d}, 32'd0);
    end
    busCycle("R1 no break after reset", 32'h0, 1'b0, 1'b1, 1'b0);
    busCycle("R1 no break after reset dma", 32'h0, 1'b1, 1'b1, 1'b0);
  endtask

  task automatic t_regmap();
    logic [15:0] d;
    regWrite(3'd0, 16'hA1B2); regWrite(3'd1, 16'hC3D4);
    regWrite(3'd2, 16'h1357); regWrite(3'd3, 16'h2468);
    regWrite(3'd5, 16'hFFFF); regWrite(3'd6, 16'hFFFF); regWrite(3'd7, 16'hFFFF);
    regRead(3'd0, d); chk("R2 addr hi", {16'd0, d}, 32'hA1B2);
    regRead(3'd1, d); chk("R2 addr lo", {16'd0, d}, 32'hC3D4);
    regRead(3'd2, d); chk("R2 mask hi", {16'd0, d}, 32'h1357);
    regRead(3'd3, d); chk("R2 mask lo", {16'd0, d}, 32'h2468);
    regRead(3'd4, d); chk("R2 cond untouched", {16'd0, d}, 32'h0);
    regRead(3'd5, d); chk("R2 hole reads 0", {16'd0, d}, 32'h0);
    regRead(3'd7, d); chk("R2 hole reads 0", {16'd0, d}, 32'h0);
  endtask

  task automatic t_cond();
    logic [15:0] d;
    regWrite(3'd4, 16'hFFFF);
    regRead(3'd4, d); chk("R3 reserved byte", {16'd0, d}, 32'h00FF);
    setBrk(32'h0000_1000, 32'h0, 16'h003F);
    regRead(3'd4, d); chk("R3 low bits stored", {16'd0, d}, 32'h003F);
    busCycle("R3 low bits do not enable", 32'h0000_1000, 1'b0, 1'b1, 1'b0);
    regWrite(3'd4, 16'h007F);
    busCycle("R3 low bits leave cpu match", 32'h0000_1000, 1'b0, 1'b1, 1'b1);
  endtask

  task automatic t_mask();
    setBrk(32'h1234_5678, 32'h0000_000F, 16'h0040);
    busCycle("R4 masked low bits", 32'h1234_567A, 1'b0, 1'b1, 1'b1);
    busCycle("R5 unmasked bit 12", 32'h1234_667A, 1'b0, 1'b1, 1'b0);
    busCycle("R5 unmasked bit 31", 32'h9234_5678, 1'b0, 1'b1, 1'b0);
    setBrk(32'h1234_5678, 32'hFF00_000F, 16'h0040);
    busCycle("R12 high mask byte", 32'hAB34_5671, 1'b0, 1'b1, 1'b1);
    busCycle("R12 high mask not low", 32'h1235_5678, 1'b0, 1'b1, 1'b0);
    busCycle("R10 invalid cycle", 32'h1234_5678, 1'b0, 1'b0, 1'b0);
  endtask

  task automatic t_select();
    string tags [4] = '{"R6 sel 00", "R7 sel 01", "R8 sel 10", "R9 sel 11"};
    for (int s = 0; s < 4; s++) begin
      setBrk(32'hCAFE_0100, 32'h0, 16'(s << 6));
      for (int m = 0; m < 2; m++)
        busCycle(tags[s], 32'hCAFE_0100, m[0], 1'b1, s[m]);
    end
  endtask

  task automatic t_backToBack();
    setBrk(32'h0000_2000, 32'h0000_0003, 16'h00C0);
    @(negedge clk);
    busAddr = 32'h0000_2001; busIsDma = 1'b0; busValid = 1'b1;
    @(negedge clk);
    chk("R11 first pulse", {31'd0, brkReq}, 32'd1);
    busAddr = 32'h0000_2002; busIsDma = 1'b1;
    @(negedge clk);
    chk("R11 second pulse", {31'd0, brkReq}, 32'd1);
    busValid = 1'b0;
    @(negedge clk);
    chk("R11 pulse ends", {31'd0, brkReq}, 32'd0);
  endtask

  initial begin
    #(20 * 20000);
    nChk++; nBad++;
    $display("FAIL watchdog: actual timeout expected completion");
    $display("== %0d vectors applied, %0d miscompares ==", nChk, nBad);
    $finish;
  end

  initial begin
    repeat (4) @(negedge clk);
    rstN = 1'b1;
    t_reset();
    t_regmap();
    t_cond();
    t_mask();
    t_select();
    t_backToBack();
    $display("== %0d vectors applied, %0d miscompares ==", nChk, nBad);
    $finish;
  end
endmodule